// File: doc/BRIEF.md
# Snooping MESI Line State Controller

This block keeps the coherence state of every line in one private cache that sits on a shared snooping bus. Each line is Modified, Exclusive, Shared or Invalid. Local processor requests (read, write, evict) arrive one at a time. For each request the controller either finishes it locally or places one bus transaction: a plain read miss, a read-for-ownership, an upgrade, or a writeback. While a transaction is in flight, the controller sits in a transient wait state. That state is released by the bus grant and then by the completion beat.

All the while, the block watches the transactions of other caches on its snoop input. In the same cycle it answers whether it holds the snooped line and whether it must supply dirty data, and it moves the line to its new state at the next edge. The answer to a requester is a wired-OR shared signal. A requester samples that signal in the cycle its own request is granted, and uses it to choose Exclusive or Shared when the fill arrives. Data arrays, replacement choice and arbitration between caches sit outside the block.

Top module: `mesiCtl`

## Requirements
- R1: After reset every line is Invalid (state code I=0, S=1, E=2, M=3), no bus request is raised, and reqReady is high.
- R2: A read to an Invalid line raises busReq with busCmd read (code 0) and busIdx set to the line. busSharedIn is sampled in the cycle busGnt is high. On busDataValid the line becomes Shared if that sample was high and Exclusive otherwise, and reqDone pulses in the next cycle with that state on doneState.
- R3: A write to an Exclusive line makes it Modified with no bus request, and reqDone pulses one cycle after acceptance with doneState M.
- R4: A write to a Shared line raises an upgrade (busCmd 2) and reaches Modified only after grant and busDataValid.
- R5: A snooped read-for-ownership (code 1) or upgrade (code 2) moves a Shared, Exclusive or Modified line to Invalid.
- R6: A snooped read (code 0) moves an Exclusive or Modified line to Shared. snoopFlush is high in the snoop cycle when the line is Modified and the snooped command is read or read-for-ownership.
- R7: snoopShared is high in the same cycle as snoopValid exactly when the snooped line is not Invalid. A writeback snoop (code 3) changes nothing.
- R8: An invalidating snoop that hits the line of a pending upgrade, before that upgrade completes, turns the request into a read-for-ownership (busCmd 1), and the line ends Modified after its fill.
- R9: Evicting a Modified line raises a writeback (busCmd 3) and leaves the line Invalid after completion. Evicting an Exclusive or Shared line makes it Invalid with no bus request, with reqDone one cycle after acceptance.
- R10: A write to an Invalid line raises a read-for-ownership (busCmd 1), and the line becomes Modified when busDataValid arrives.
- R11: A read to a valid line and a write to a Modified line complete with no bus request, with reqDone one cycle after acceptance and the unchanged state on doneState.
- R12: If a snoop hits a line waiting to be written back, before the writeback is granted, the writeback is dropped. The eviction then completes at once with doneState I.
- R13: reqReady is low while a request is in flight and in any cycle where snoopValid is high. Requests are operation code 0 read, 1 write, 2 evict, and 3 is treated as a read.
- R14: Two controllers on one bus, running core 0 read, core 1 read, then core 0 write to one line, pass through the state pairs (I,I), (E,I), (S,S), (M,I).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Local request present |
| reqOp | input | 2 | 0 read, 1 write, 2 evict, 3 read |
| reqIdx | input | IDX_W | Line addressed by the local request |
| reqReady | output | 1 | Request accepted when high together with reqValid |
| reqDone | output | 1 | One-cycle pulse when a request completes |
| doneState | output | 2 | Line state after the completed request |
| busReq | output | 1 | Bus transaction requested |
| busCmd | output | 2 | 0 read, 1 read-for-ownership, 2 upgrade, 3 writeback |
| busIdx | output | IDX_W | Line of the bus transaction |
| busGnt | input | 1 | Bus grant for the pending request |
| busDataValid | input | 1 | Completion beat (fill data or acknowledge) |
| busSharedIn | input | 1 | Wired-OR shared response from other caches |
| snoopValid | input | 1 | Remote transaction visible on the bus |
| snoopCmd | input | 2 | Command of the remote transaction |
| snoopIdx | input | IDX_W | Line of the remote transaction |
| snoopShared | output | 1 | This cache holds the snooped line |
| snoopFlush | output | 1 | This cache must supply dirty data |

## Verification
The bench aims at the races inside the transient states. An invalidation that lands on a pending upgrade must become a read-for-ownership. A design that kept the upgrade would report Modified over data it no longer holds, and the bench would see busCmd stay at 2. A snoop that lands on a pending writeback must cancel the writeback. If it did not, the line would be written back after another cache already took the data, and the bus would show a stale writeback request. The bench also samples the shared response at grant rather than at fill, because a controller that samples late picks Exclusive or Shared from the wrong cycle. It runs the two-core sequence on two connected instances, so that a missing Exclusive-to-Shared downgrade or a missing dirty flush shows up at the peer.

// File: rtl/mesiPkg.sv
package mesiPkg;

  typedef enum logic [1:0] {
    LINE_I = 2'd0,
    LINE_S = 2'd1,
    LINE_E = 2'd2,
    LINE_M = 2'd3
  } lineState_t;

  typedef enum logic [1:0] {
    BUS_RD  = 2'd0,
    BUS_RDX = 2'd1,
    BUS_UPG = 2'd2,
    BUS_WB  = 2'd3
  } busCmd_t;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_EVICT = 2'd2,
    OP_ALT   = 2'd3
  } reqOp_t;

  // control -> datapath strobes
  typedef struct packed {
    logic       capture;   // latch reqIdx as the held line, write targets reqIdx
    logic       lineWe;    // local state write
    lineState_t lineNew;
  } strobe_t;

  // datapath -> control status
  typedef struct packed {
    lineState_t reqState;   // state of line at reqIdx
    lineState_t heldState;  // state of the held line
    logic       snoopKill;  // invalidating snoop on held line
    logic       snoopTouch; // any state-changing snoop on held line
  } status_t;

  function automatic lineState_t snoopNext(lineState_t cur, busCmd_t cmd);
    lineState_t nxt;
    nxt = cur;
    unique case (cmd)
      BUS_RD:  if (cur == LINE_E || cur == LINE_M) nxt = LINE_S;
      BUS_RDX: nxt = LINE_I;
      BUS_UPG: nxt = LINE_I;
      BUS_WB:  nxt = cur;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/mesiLineStore.sv
module mesiLineStore
  import mesiPkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int IDX_W = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [IDX_W-1:0] reqIdx,
  input  logic             snoopValid,
  input  logic [1:0]       snoopCmd,
  input  logic [IDX_W-1:0] snoopIdx,
  output status_t          stat,
  output logic [IDX_W-1:0] heldIdx,
  output logic             snoopShared,
  output logic             snoopFlush
);

  lineState_t       lines [NUM_LINES];
  logic [IDX_W-1:0] wIdx;
  busCmd_t          sCmd;
  lineState_t       sState;
  logic             sInval;

  assign sCmd   = busCmd_t'(snoopCmd);
  assign wIdx   = strb.capture ? reqIdx : heldIdx;
  assign sState = lines[snoopIdx];
  assign sInval = (sCmd == BUS_RDX) || (sCmd == BUS_UPG);

  always_ff @(posedge clk) begin
    if (!rstN) heldIdx <= '0;
    else if (strb.capture) heldIdx <= reqIdx;
  end

  // one state register per line; a local write wins over a snoop on the same line
  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    always_ff @(posedge clk) begin
      if (!rstN) lines[g] <= LINE_I;
      else if (strb.lineWe && wIdx == IDX_W'(g)) lines[g] <= strb.lineNew;
      else if (snoopValid && snoopIdx == IDX_W'(g)) lines[g] <= snoopNext(lines[g], sCmd);
    end
  end

  assign snoopShared = snoopValid && (sState != LINE_I);
  assign snoopFlush  = snoopValid && (sState == LINE_M) && ((sCmd == BUS_RD) || (sCmd == BUS_RDX));

  assign stat.reqState   = lines[reqIdx];
  assign stat.heldState  = lines[heldIdx];
  assign stat.snoopKill  = snoopValid && (snoopIdx == heldIdx) && sInval;
  assign stat.snoopTouch = snoopValid && (snoopIdx == heldIdx) && (sCmd != BUS_WB);

  // R5: invalidating snoop leaves the line Invalid unless a local write targets it
  assert_snoop_inv_R5: assert property (@(posedge clk) disable iff (!rstN)
    (snoopValid && sInval && !(strb.lineWe && wIdx == snoopIdx))
      |=> lines[$past(snoopIdx)] == LINE_I);

  // R6: a flushing line never stays Modified
  assert_flush_clean_R6: assert property (@(posedge clk) disable iff (!rstN)
    snoopFlush |=> lines[$past(snoopIdx)] != LINE_M);

endmodule

// File: rtl/mesiCtrl.sv
module mesiCtrl
  import mesiPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  status_t    stat,
  input  logic       busGnt,
  input  logic       busDataValid,
  input  logic       busSharedIn,
  input  logic       snoopValid,
  output strobe_t    strb,
  output logic       reqReady,
  output logic       reqDone,
  output lineState_t doneState,
  output logic       busReq,
  output busCmd_t    busCmd
);

  typedef enum logic [3:0] {
    ST_IDLE, ST_ISS_RD, ST_ISS_RDX, ST_ISS_UPG, ST_ISS_WB,
    ST_WT_RD, ST_WT_RDX, ST_WT_UPG, ST_WT_WB
  } ctlState_t;

  ctlState_t  state, nextState;
  logic       sharedSeen, sharedNext;
  logic       doneNext;
  lineState_t doneStateNext;
  logic       accept;
  reqOp_t     op;

  assign op       = reqOp_t'(reqOp);
  assign reqReady = (state == ST_IDLE) && !snoopValid;
  assign accept   = reqValid && reqReady;

  always_comb begin
    nextState     = state;
    strb          = '0;
    doneNext      = 1'b0;
    doneStateNext = doneState;
    sharedNext    = sharedSeen;
    unique case (state)
      ST_IDLE: if (accept) begin
        strb.capture = 1'b1;
        unique case (op)
          OP_EVICT: begin
            if (stat.reqState == LINE_M) nextState = ST_ISS_WB;
            else begin
              strb.lineWe   = 1'b1;
              strb.lineNew  = LINE_I;
              doneNext      = 1'b1;
              doneStateNext = LINE_I;
            end
          end
          OP_WRITE: begin
            unique case (stat.reqState)
              LINE_I: nextState = ST_ISS_RDX;
              LINE_S: nextState = ST_ISS_UPG;
              LINE_E: begin
                strb.lineWe   = 1'b1;
                strb.lineNew  = LINE_M;
                doneNext      = 1'b1;
                doneStateNext = LINE_M;
              end
              LINE_M: begin
                doneNext      = 1'b1;
                doneStateNext = LINE_M;
              end
            endcase
          end
          default: begin
            if (stat.reqState == LINE_I) nextState = ST_ISS_RD;
            else begin
              doneNext      = 1'b1;
              doneStateNext = stat.reqState;
            end
          end
        endcase
      end
      ST_ISS_RD: if (busGnt) begin
        nextState  = ST_WT_RD;
        sharedNext = busSharedIn;
      end
      ST_WT_RD: if (busDataValid) begin
        strb.lineWe   = 1'b1;
        strb.lineNew  = sharedSeen ? LINE_S : LINE_E;
        doneNext      = 1'b1;
        doneStateNext = sharedSeen ? LINE_S : LINE_E;
        nextState     = ST_IDLE;
      end
      ST_ISS_RDX: if (busGnt) nextState = ST_WT_RDX;
      ST_WT_RDX: if (busDataValid) begin
        strb.lineWe   = 1'b1;
        strb.lineNew  = LINE_M;
        doneNext      = 1'b1;
        doneStateNext = LINE_M;
        nextState     = ST_IDLE;
      end
      ST_ISS_UPG: begin
        if (stat.snoopKill) nextState = ST_ISS_RDX;
        else if (busGnt) nextState = ST_WT_UPG;
      end
      ST_WT_UPG: begin
        if (stat.snoopKill) nextState = ST_ISS_RDX;
        else if (busDataValid) begin
          strb.lineWe   = 1'b1;
          strb.lineNew  = LINE_M;
          doneNext      = 1'b1;
          doneStateNext = LINE_M;
          nextState     = ST_IDLE;
        end
      end
      ST_ISS_WB: begin
        if (stat.snoopTouch) begin
          strb.lineWe   = 1'b1;
          strb.lineNew  = LINE_I;
          doneNext      = 1'b1;
          doneStateNext = LINE_I;
          nextState     = ST_IDLE;
        end else if (busGnt) nextState = ST_WT_WB;
      end
      ST_WT_WB: if (busDataValid) begin
        strb.lineWe   = 1'b1;
        strb.lineNew  = LINE_I;
        doneNext      = 1'b1;
        doneStateNext = LINE_I;
        nextState     = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      sharedSeen <= 1'b0;
      reqDone    <= 1'b0;
      doneState  <= LINE_I;
    end else begin
      state      <= nextState;
      sharedSeen <= sharedNext;
      reqDone    <= doneNext;
      doneState  <= doneStateNext;
    end
  end

  always_comb begin
    busReq = 1'b1;
    busCmd = BUS_RD;
    unique case (state)
      ST_ISS_RD:  busCmd = BUS_RD;
      ST_ISS_RDX: busCmd = BUS_RDX;
      ST_ISS_UPG: busCmd = BUS_UPG;
      ST_ISS_WB:  busCmd = BUS_WB;
      default:    busReq = 1'b0;
    endcase
  end

  // R3: silent write on an Exclusive line
  assert_silent_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    (accept && op == OP_WRITE && stat.reqState == LINE_E)
      |=> (!busReq && reqDone && doneState == LINE_M));

  // R2: a read fill always completes with a clean state
  assert_fill_clean_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WT_RD && busDataValid)
      |=> (reqDone && (doneState == LINE_E || doneState == LINE_S)));

  // R8: an invalidated upgrade turns into a read-for-ownership
  assert_upg_race_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ISS_UPG && stat.snoopKill) |=> (busReq && busCmd == BUS_RDX));

  // R13: a miss request stays raised until granted
  assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busGnt && (busCmd == BUS_RD || busCmd == BUS_RDX)) |=> busReq);

  // R12: a touched pending writeback is dropped
  assert_wb_drop_R12: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ISS_WB && stat.snoopTouch)
      |=> (!busReq && reqDone && doneState == LINE_I));

endmodule

// File: rtl/mesiCtl.sv
module mesiCtl
  import mesiPkg::*;
#(
  parameter int NUM_LINES = 16,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqOp,
  input  logic [IDX_W-1:0] reqIdx,
  output logic             reqReady,
  output logic             reqDone,
  output logic [1:0]       doneState,
  output logic             busReq,
  output logic [1:0]       busCmd,
  output logic [IDX_W-1:0] busIdx,
  input  logic             busGnt,
  input  logic             busDataValid,
  input  logic             busSharedIn,
  input  logic             snoopValid,
  input  logic [1:0]       snoopCmd,
  input  logic [IDX_W-1:0] snoopIdx,
  output logic             snoopShared,
  output logic             snoopFlush
);

  strobe_t    strb;
  status_t    stat;
  lineState_t doneEnum;
  busCmd_t    cmdEnum;

  mesiLineStore #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rstN(rstN), .strb(strb), .reqIdx(reqIdx),
    .snoopValid(snoopValid), .snoopCmd(snoopCmd), .snoopIdx(snoopIdx),
    .stat(stat), .heldIdx(busIdx),
    .snoopShared(snoopShared), .snoopFlush(snoopFlush)
  );

  mesiCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .stat(stat), .busGnt(busGnt), .busDataValid(busDataValid),
    .busSharedIn(busSharedIn), .snoopValid(snoopValid),
    .strb(strb), .reqReady(reqReady), .reqDone(reqDone),
    .doneState(doneEnum), .busReq(busReq), .busCmd(cmdEnum)
  );

  assign doneState = doneEnum;
  assign busCmd    = cmdEnum;

endmodule

// File: tb/mesiCtl_tb.sv
module mesiCtl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // core 0 (u_dut) stimulus
  logic dV = 0, dGnt = 0, dData = 0;
  logic [1:0] dOp = 0;
  logic [IW-1:0] dIdx = 0;
  // core 1 (u_peer) stimulus
  logic pV = 0, pGnt = 0, pData = 0;
  logic [1:0] pOp = 0;
  logic [IW-1:0] pIdx = 0;
  // injected snoop toward core 0
  logic injV = 0, injSh = 0;
  logic [1:0] injCmd = 0;
  logic [IW-1:0] injIdx = 0;

  logic dReady, dDone, dReq, dShared, dFlush;
  logic [1:0] dDoneSt, dCmd;
  logic [IW-1:0] dBusIdx;
  logic pReady, pDone, pReq, pShared, pFlush;
  logic [1:0] pDoneSt, pCmd;
  logic [IW-1:0] pBusIdx;

  logic dSnV, pSnV;
  logic [1:0] dSnCmd;
  logic [IW-1:0] dSnIdx;
  assign dSnV   = injV | (pReq & pGnt);
  assign dSnCmd = injV ? injCmd : pCmd;
  assign dSnIdx = injV ? injIdx : pBusIdx;
  assign pSnV   = dReq & dGnt;

  mesiCtl #(.NUM_LINES(16)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(dV), .reqOp(dOp), .reqIdx(dIdx),
    .reqReady(dReady), .reqDone(dDone), .doneState(dDoneSt),
    .busReq(dReq), .busCmd(dCmd), .busIdx(dBusIdx), .busGnt(dGnt),
    .busDataValid(dData), .busSharedIn(injSh | pShared),
    .snoopValid(dSnV), .snoopCmd(dSnCmd), .snoopIdx(dSnIdx),
    .snoopShared(dShared), .snoopFlush(dFlush));

  mesiCtl #(.NUM_LINES(16)) u_peer (
    .clk(clk), .rstN(rstN), .reqValid(pV), .reqOp(pOp), .reqIdx(pIdx),
    .reqReady(pReady), .reqDone(pDone), .doneState(pDoneSt),
    .busReq(pReq), .busCmd(pCmd), .busIdx(pBusIdx), .busGnt(pGnt),
    .busDataValid(pData), .busSharedIn(dShared),
    .snoopValid(pSnV), .snoopCmd(dCmd), .snoopIdx(dBusIdx),
    .snoopShared(pShared), .snoopFlush(pFlush));

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic issue(bit peer, logic [1:0] op, logic [IW-1:0] idx);
    if (peer) begin pV = 1; pOp = op; pIdx = idx; end
    else begin dV = 1; dOp = op; dIdx = idx; end
    @(negedge clk);
    dV = 0; pV = 0;
  endtask

  task automatic grant(bit peer, logic sh);
    if (peer) pGnt = 1; else begin dGnt = 1; injSh = sh; end
    @(negedge clk);
    dGnt = 0; pGnt = 0; injSh = 0;
  endtask

  task automatic fill(bit peer);
    if (peer) pData = 1; else dData = 1;
    @(negedge clk);
    dData = 0; pData = 0;
  endtask

  task automatic probe(logic [1:0] cmd, logic [IW-1:0] idx, output logic sh, output logic fl);
    injV = 1; injCmd = cmd; injIdx = idx;
    #1;
    sh = dShared; fl = dFlush;
    @(negedge clk);
    injV = 0;
  endtask

  // read miss on core 0 ending in expState
  task automatic readMiss(logic [IW-1:0] idx, logic sh);
    issue(0, 0, idx);
    grant(0, sh);
    fill(0);
  endtask

  task automatic tReset();
    logic s, f;
    check("R1 reqReady", dReady, 1);
    check("R1 busReq", dReq, 0);
    probe(0, 0, s, f);
    check("R1 line0 invalid", s, 0);
  endtask

  task automatic tReadMiss();
    issue(0, 0, 1);
    check("R2 busReq", dReq, 1);
    check("R2 busCmd rd", dCmd, 0);
    check("R2 busIdx", dBusIdx, 1);
    check("R13 busy not ready", dReady, 0);
    grant(0, 0);
    check("R2 req dropped after grant", dReq, 0);
    fill(0);
    check("R2 done", dDone, 1);
    check("R2 fill exclusive", dDoneSt, 2);
    issue(0, 3, 1);
    check("R11 read hit done", dDone, 1);
    check("R11 read hit state", dDoneSt, 2);
    check("R11 read hit no bus", dReq, 0);
  endtask

  task automatic tSilentWrite();
    issue(0, 1, 1);
    check("R3 done", dDone, 1);
    check("R3 state M", dDoneSt, 3);
    check("R3 no bus", dReq, 0);
    issue(0, 1, 1);
    check("R11 write hit M", dDoneSt, 3);
    check("R11 write hit no bus", dReq, 0);
  endtask

  task automatic tSnoopRead();
    logic s, f;
    probe(0, 1, s, f);
    check("R7 shared on M", s, 1);
    check("R6 flush on M", f, 1);
    issue(0, 0, 1);
    check("R6 M to S", dDoneSt, 1);
    readMiss(4, 0);
    check("R2 idx4 E", dDoneSt, 2);
    probe(0, 4, s, f);
    check("R7 shared on E", s, 1);
    check("R6 no flush on E", f, 0);
    probe(3, 4, s, f);
    check("R7 wb snoop shared", s, 1);
    issue(0, 0, 4);
    check("R6 E to S", dDoneSt, 1);
  endtask

  task automatic tUpgrade();
    logic s, f;
    readMiss(2, 1);
    check("R2 fill shared", dDoneSt, 1);
    issue(0, 1, 2);
    check("R4 upgrade req", dReq, 1);
    check("R4 upgrade cmd", dCmd, 2);
    grant(0, 0);
    check("R4 not done before ack", dDone, 0);
    fill(0);
    check("R4 done", dDone, 1);
    check("R4 state M", dDoneSt, 3);
    probe(1, 2, s, f);
    check("R6 flush on rdx", f, 1);
    probe(0, 2, s, f);
    check("R5 rdx invalidates", s, 0);
    probe(2, 4, s, f);
    check("R7 S shared", s, 1);
    probe(0, 4, s, f);
    check("R5 upg invalidates S", s, 0);
  endtask

  task automatic tWriteMissEvict();
    logic s, f;
    issue(0, 1, 3);
    check("R10 rdx cmd", dCmd, 1);
    grant(0, 0);
    fill(0);
    check("R10 state M", dDoneSt, 3);
    issue(0, 2, 3);
    check("R9 wb cmd", dCmd, 3);
    check("R9 wb req", dReq, 1);
    grant(0, 0);
    fill(0);
    check("R9 wb done", dDone, 1);
    check("R9 wb state I", dDoneSt, 0);
    probe(0, 3, s, f);
    check("R9 evicted line invalid", s, 0);
    readMiss(5, 0);
    issue(0, 2, 5);
    check("R9 silent evict done", dDone, 1);
    check("R9 silent evict I", dDoneSt, 0);
    check("R9 silent evict no bus", dReq, 0);
  endtask

  task automatic tUpgradeRace();
    readMiss(6, 1);
    issue(0, 1, 6);
    check("R8 upgrade issued", dCmd, 2);
    injV = 1; injCmd = 2; injIdx = 6;
    @(negedge clk);
    injV = 0;
    check("R8 converted req", dReq, 1);
    check("R8 converted cmd", dCmd, 1);
    grant(0, 0);
    fill(0);
    check("R8 done", dDone, 1);
    check("R8 state M", dDoneSt, 3);
  endtask

  task automatic tWbAbandon();
    logic s, f;
    issue(0, 1, 9);
    grant(0, 0);
    fill(0);
    issue(0, 2, 9);
    check("R12 wb pending", dCmd, 3);
    probe(0, 9, s, f);
    check("R12 flush", f, 1);
    check("R12 done", dDone, 1);
    check("R12 state I", dDoneSt, 0);
    check("R12 wb dropped", dReq, 0);
    probe(0, 9, s, f);
    check("R12 line invalid", s, 0);
  endtask

  task automatic tReadyBlock();
    injV = 1; injCmd = 0; injIdx = 0;
    #1;
    check("R13 snoop blocks ready", dReady, 0);
    @(negedge clk);
    injV = 0;
    #1;
    check("R13 ready back", dReady, 1);
  endtask

  task automatic tTwoCore();
    issue(0, 0, 7);
    grant(0, 0);
    fill(0);
    check("R14 c0 E", dDoneSt, 2);
    issue(1, 0, 7);
    check("R14 c1 miss", pReq, 1);
    pGnt = 1;
    #1;
    check("R14 c0 answers shared", dShared, 1);
    @(negedge clk);
    pGnt = 0;
    fill(1);
    check("R14 c1 S", pDoneSt, 1);
    issue(0, 0, 7);
    check("R14 c0 S", dDoneSt, 1);
    issue(0, 1, 7);
    check("R14 c0 upgrade", dCmd, 2);
    grant(0, 0);
    fill(0);
    check("R14 c0 M", dDoneSt, 3);
    issue(1, 0, 7);
    check("R14 c1 invalid so misses", pReq, 1);
    check("R14 c1 miss cmd", pCmd, 0);
    pGnt = 1;
    #1;
    check("R14 c0 flushes dirty", dFlush, 1);
    @(negedge clk);
    pGnt = 0;
    fill(1);
    check("R14 c1 refilled S", pDoneSt, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tReset();
    tReadMiss();
    tSilentWrite();
    tSnoopRead();
    tUpgrade();
    tWriteMissEvict();
    tUpgradeRace();
    tWbAbandon();
    tReadyBlock();
    tTwoCore();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule